// File: doc/BRIEF.md
# Multi-Speed SCL Clock Generator

This block produces the serial clock of a two-wire bus master. It drives the line low for a programmed number of cycles, then lets it go and waits for it to read back high. Once the line is high it counts the high time. The block holds three high/low count pairs, one for each of the standard, fast and high speed rates, and a two-bit speed code picks the pair in use. A build without high-speed support runs any high-speed request at the fast rate.

Besides the open-drain drive it gives a bit engine three timing marks. The high-phase indicator is set while the high time is being counted. A one-cycle strobe marks the middle of the counted high time, which is where SDA is sampled. A one-cycle strobe marks the first cycle of each low phase, which is where SDA may change. A slave may hold the line low to stretch the clock. The high count does not begin until the released line has come back high through a two-stage synchroniser. While the enable is low the line is released and all marks stay quiet.

Top module: `scl_period_gen`

## Requirements
- R1: While `enable` is low, and from reset, `scl_oe` is 0 and `scl_hi_phase`, `hi_mid_stb` and `lo_start_stb` are all 0.
- R2: Each low phase holds `scl_oe` at 1 for exactly L+1 consecutive cycles, where L is the effective low count, and `lo_start_stb` is 1 in the first of those cycles only.
- R3: With no stretching (the line reads high in the first released cycle), `scl_oe` stays 0 for exactly H+8 cycles between low phases, where H is the effective high count.
- R4: The speed code selects the count pair: 2'b01 standard, 2'b10 fast, 2'b11 high speed, and 2'b00 behaves as standard.
- R5: When the parameter `HS_SUPPORT` is 0, speed code 2'b11 uses the fast pair.
- R6: A high count below 6 is treated as 6, and a low count below 8 is treated as 8.
- R7: If the line stays low for S cycles after release, the released time becomes S+H+8 cycles. The high count starts only after the line has read high on three consecutive clock edges through the synchroniser.
- R8: `scl_hi_phase` is 1 for the last H+5 released cycles of each period. `hi_mid_stb` is 1 in exactly one of them: released cycle S+3+((H+4)>>1), counting the first released cycle as 0.
- R9: The first low phase begins in the cycle after `enable` is first sampled high. A low `enable` returns the line to released in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the clock when 1; idle and release when 0 |
| spd_sel | input | 2 | Speed code: 01 standard, 10 fast, 11 high, 00 standard |
| std_hi_cnt | input | CNT_W | Standard-rate high count |
| std_lo_cnt | input | CNT_W | Standard-rate low count |
| fst_hi_cnt | input | CNT_W | Fast-rate high count |
| fst_lo_cnt | input | CNT_W | Fast-rate low count |
| hsp_hi_cnt | input | CNT_W | High-speed high count |
| hsp_lo_cnt | input | CNT_W | High-speed low count |
| scl_in | input | 1 | Sensed level of the bus clock line |
| scl_oe | output | 1 | 1 pulls the clock line low; 0 releases it |
| scl_hi_phase | output | 1 | Counted high time in progress |
| hi_mid_stb | output | 1 | One-cycle mark at the middle of the counted high time |
| lo_start_stb | output | 1 | One-cycle mark in the first cycle of a low phase |

## Verification
Each speed code is run with all three pairs loaded with different values. The measured low and released lengths therefore show which pair was selected, and the reserved code is checked to land on the standard pair. Counts below the minimums are set against counts exactly at them, so a missing clamp or an off-by-one in the clamp shows up in the period lengths. Stretch lengths of 0, 1 and 5 cycles separate a high counter that waits for the synchroniser from one that starts at release. The timing of the mid strobe is compared in every period. A second build without high-speed support runs with the same inputs to expose the fallback.

// File: rtl/scl_gen_pkg.sv
// Shared types and constants for the SCL period generator.
// Assumes: the speed code encoding and the phase timing constants below are
// the single source used by every module of the block.
package scl_gen_pkg;

    // Speed selector code as seen on the spd_sel port.
    typedef enum logic [1:0] {
        SPD_RSV = 2'b00,
        SPD_STD = 2'b01,
        SPD_FST = 2'b10,
        SPD_HSP = 2'b11
    } spd_e;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_WAIT = 2'b10,
        PH_HIGH = 2'b11
    } phase_e;

    // Smallest high and low counts honoured.
    localparam int unsigned HI_MIN      = 6;
    localparam int unsigned LO_MIN      = 8;
    // Fixed released-time overhead on top of the high count.
    localparam int unsigned HI_OVERHEAD = 8;
    // Depth of the line synchroniser.
    localparam int unsigned SYNC_STAGES = 2;
    // Released cycles spent before the high counter starts (synchroniser
    // plus one decision cycle), and the resulting terminal offset.
    localparam int unsigned WAIT_CYC    = SYNC_STAGES + 1;
    localparam int unsigned HI_TERM_ADD = HI_OVERHEAD - WAIT_CYC - 1;

endpackage

// File: rtl/scl_sync.sv
// Multi-stage synchroniser for the sensed clock line.
// Assumes: the line idles high, so every stage resets to 1.
module scl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/scl_cnt_sel.sv
// Picks the active high/low count pair from the speed code, applies the
// minimum clamps and converts them into terminal values for the phase
// counter. Purely combinational.
// Assumes: counts are stable for the duration of a phase.
module scl_cnt_sel
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter bit          HS_SUPPORT = 1'b1
) (
    input  logic [1:0]     spd_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fst_hi,
    input  logic [CNT_W-1:0] fst_lo,
    input  logic [CNT_W-1:0] hsp_hi,
    input  logic [CNT_W-1:0] hsp_lo,
    output logic [CNT_W:0]   hi_term,
    output logic [CNT_W:0]   lo_term
);
    localparam int unsigned TW = CNT_W + 1;
    localparam logic [TW-1:0] HI_MIN_W = TW'(HI_MIN);
    localparam logic [TW-1:0] LO_MIN_W = TW'(LO_MIN);
    localparam logic [TW-1:0] HI_ADD_W = TW'(HI_TERM_ADD);

    spd_e             spd_eff;
    logic [CNT_W-1:0] hi_raw;
    logic [CNT_W-1:0] lo_raw;
    logic [TW-1:0]    hi_clamp;
    logic [TW-1:0]    lo_clamp;

    // Resolve the speed code the build can actually run.
    generate
        if (HS_SUPPORT) begin : g_hs
            always_comb begin
                spd_eff = spd_e'(spd_sel);
            end
        end else begin : g_nohs
            always_comb begin
                spd_eff = (spd_e'(spd_sel) == SPD_HSP) ? SPD_FST : spd_e'(spd_sel);
            end
        end
    endgenerate

    // Route the selected count pair.
    always_comb begin
        unique case (spd_eff)
            SPD_FST: begin hi_raw = fst_hi; lo_raw = fst_lo; end
            SPD_HSP: begin hi_raw = hsp_hi; lo_raw = hsp_lo; end
            default: begin hi_raw = std_hi; lo_raw = std_lo; end
        endcase
    end

    // Clamp to the minimums and derive the counter terminals.
    always_comb begin
        hi_clamp = ({1'b0, hi_raw} < HI_MIN_W) ? HI_MIN_W : {1'b0, hi_raw};
        lo_clamp = ({1'b0, lo_raw} < LO_MIN_W) ? LO_MIN_W : {1'b0, lo_raw};
        hi_term  = hi_clamp + HI_ADD_W;
        lo_term  = lo_clamp;
    end
endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: low phase of lo_term+1 cycles, release and wait for the
// synchronised line to read high, then hi_term+1 counted high cycles.
// Assumes: sync_hi is the synchronised line level; it reads low by the end of
// any low phase because the low phase is longer than the synchroniser.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           sync_hi,
    input  logic [CNT_W:0] hi_term,
    input  logic [CNT_W:0] lo_term,
    output logic           drive_low,
    output logic           hi_phase,
    output logic           mid_stb,
    output logic           lo_stb
);
    phase_e         phase;
    logic [CNT_W:0] cnt;
    logic [CNT_W:0] mid_pt;

    // Advance the phase and the shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (!enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (cnt >= lo_term) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (sync_hi) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end
                end
                PH_HIGH: begin
                    if (cnt >= hi_term) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Decode the pin drive and the timing marks from the phase state.
    always_comb begin
        mid_pt    = hi_term >> 1;
        drive_low = (phase == PH_LOW);
        hi_phase  = (phase == PH_HIGH);
        mid_stb   = (phase == PH_HIGH) && (cnt == mid_pt);
        lo_stb    = (phase == PH_LOW) && (cnt == '0);
    end
endmodule

// File: rtl/scl_period_gen.sv
// Top of the multi-speed SCL period generator: count selection, line
// synchroniser and phase sequencer.
// Assumes: scl_in reflects the wired-AND level of the bus clock line and
// scl_oe drives an open-drain pull-down.
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter bit          HS_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       spd_sel,
    input  logic [CNT_W-1:0] std_hi_cnt,
    input  logic [CNT_W-1:0] std_lo_cnt,
    input  logic [CNT_W-1:0] fst_hi_cnt,
    input  logic [CNT_W-1:0] fst_lo_cnt,
    input  logic [CNT_W-1:0] hsp_hi_cnt,
    input  logic [CNT_W-1:0] hsp_lo_cnt,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             scl_hi_phase,
    output logic             hi_mid_stb,
    output logic             lo_start_stb
);
    logic [CNT_W:0] hi_term;
    logic [CNT_W:0] lo_term;
    logic           scl_sync_hi;

    scl_cnt_sel #(
        .CNT_W      (CNT_W),
        .HS_SUPPORT (HS_SUPPORT)
    ) u_sel (
        .spd_sel (spd_sel),
        .std_hi  (std_hi_cnt),
        .std_lo  (std_lo_cnt),
        .fst_hi  (fst_hi_cnt),
        .fst_lo  (fst_lo_cnt),
        .hsp_hi  (hsp_hi_cnt),
        .hsp_lo  (hsp_lo_cnt),
        .hi_term (hi_term),
        .lo_term (lo_term)
    );

    scl_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .dout  (scl_sync_hi)
    );

    scl_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sync_hi   (scl_sync_hi),
        .hi_term   (hi_term),
        .lo_term   (lo_term),
        .drive_low (scl_oe),
        .hi_phase  (scl_hi_phase),
        .mid_stb   (hi_mid_stb),
        .lo_stb    (lo_start_stb)
    );
endmodule

// File: rtl/scl_period_gen_chk.sv
// Property checker for scl_period_gen, attached by bind.
// Assumes: observes only the ports of the generator.
module scl_period_gen_chk
    import scl_gen_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_oe,
    input logic scl_hi_phase,
    input logic hi_mid_stb,
    input logic lo_start_stb
);
    int unsigned lo_run;

    // Length of the current run of driven-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= 0;
        end else begin
            lo_run <= scl_oe ? lo_run + 1 : 0;
        end
    end

    // R1: a sampled-low enable leaves the line released and all marks quiet.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!scl_oe && !scl_hi_phase && !hi_mid_stb && !lo_start_stb));

    // R2: every new low phase opens with the low-start mark.
    p_low_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> lo_start_stb);

    // R2: the low-start mark only appears while the line is driven.
    p_lo_mark_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_start_stb |-> (scl_oe && !scl_hi_phase));

    // R6: a low phase that ends while enabled lasted at least the minimum.
    p_low_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(scl_oe) && $past(enable)) |-> (lo_run >= LO_MIN + 1));

    // R7: counted high time begins only after the line read high.
    p_high_after_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hi_phase) |-> $past(scl_in, 3));

    // R8: the mid mark sits inside the counted high time, line released.
    p_mid_in_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_mid_stb |-> (scl_hi_phase && !scl_oe));

    // R8: the counted high time never overlaps a driven-low cycle.
    p_high_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hi_phase |-> !scl_oe);
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .scl_in       (scl_in),
    .scl_oe       (scl_oe),
    .scl_hi_phase (scl_hi_phase),
    .hi_mid_stb   (hi_mid_stb),
    .lo_start_stb (lo_start_stb)
);

// File: tb/tb_scl_period_gen.sv
// Scoreboard bench: the driver queues the expected period shape, a monitor
// measures each completed period at the ports and compares.
module tb_scl_period_gen;
    localparam int CNT_W = 16;
    localparam int WATCHDOG = 150000;

    typedef struct {
        int    lo;
        int    rel;
        int    mid;
        int    hip;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [1:0]       spd_sel = 2'b01;
    logic [CNT_W-1:0] std_hi = 16'd10, std_lo = 16'd12;
    logic [CNT_W-1:0] fst_hi = 16'd7,  fst_lo = 16'd9;
    logic [CNT_W-1:0] hsp_hi = 16'd6,  hsp_lo = 16'd8;
    logic             scl_in, scl_oe, scl_hi_phase, hi_mid_stb, lo_start_stb;
    logic             nh_in, nh_oe, nh_hip, nh_mid, nh_lo;
    int               stretch_n = 0;
    int               rel_cyc = 0;

    int   n_checks = 0;
    int   n_fails = 0;
    int   pending = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    // Slave model: holds the line low for stretch_n released cycles.
    always @(posedge clk) rel_cyc <= scl_oe ? 0 : rel_cyc + 1;
    assign scl_in = ~scl_oe & (rel_cyc >= stretch_n);
    assign nh_in  = ~nh_oe;

    scl_period_gen #(.CNT_W(CNT_W), .HS_SUPPORT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .spd_sel(spd_sel),
        .std_hi_cnt(std_hi), .std_lo_cnt(std_lo),
        .fst_hi_cnt(fst_hi), .fst_lo_cnt(fst_lo),
        .hsp_hi_cnt(hsp_hi), .hsp_lo_cnt(hsp_lo),
        .scl_in(scl_in), .scl_oe(scl_oe), .scl_hi_phase(scl_hi_phase),
        .hi_mid_stb(hi_mid_stb), .lo_start_stb(lo_start_stb));

    scl_period_gen #(.CNT_W(CNT_W), .HS_SUPPORT(1'b0)) dut_nohs (
        .clk(clk), .rst_n(rst_n), .enable(enable), .spd_sel(spd_sel),
        .std_hi_cnt(std_hi), .std_lo_cnt(std_lo),
        .fst_hi_cnt(fst_hi), .fst_lo_cnt(fst_lo),
        .hsp_hi_cnt(hsp_hi), .hsp_lo_cnt(hsp_lo),
        .scl_in(nh_in), .scl_oe(nh_oe), .scl_hi_phase(nh_hip),
        .hi_mid_stb(nh_mid), .lo_start_stb(nh_lo));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(!scl_oe && !scl_hi_phase && !hi_mid_stb && !lo_start_stb, req,
              {scl_oe, scl_hi_phase, hi_mid_stb, lo_start_stb}, 0);
    endtask

    // Monitor: measures each complete period and compares with the queue.
    initial begin
        int   mode = 0;
        int   lo = 0, rel = 0, mid = -1, hip = 0, mids = 0;
        bit   ls_ok = 1'b0;
        bit   prev_oe = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!enable) begin
                mode = 0;
            end else if (scl_oe && !prev_oe) begin
                if (mode == 2) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected period", lo, 0);
                    end else begin
                        e = exp_q.pop_front();
                        pending--;
                        check(ls_ok && lo == e.lo && rel == e.rel && mid == e.mid
                              && mids == 1 && hip == e.hip,
                              $sformatf("%s period lo/rel/mid/hip=%0d/%0d/%0d/%0d vs %0d/%0d/%0d/%0d",
                                        e.tag, lo, rel, mid, hip, e.lo, e.rel, e.mid, e.hip),
                              rel, e.rel);
                    end
                end
                mode = 1; lo = 1; rel = 0; mid = -1; hip = 0; mids = 0;
                ls_ok = lo_start_stb;
            end else if (scl_oe && mode == 1) begin
                lo++;
                if (lo_start_stb) ls_ok = 1'b0;
            end else if (!scl_oe && mode != 0) begin
                if (mode == 1) begin
                    mode = 2;
                    rel = 0;
                end
                if (hi_mid_stb) begin
                    mid = rel;
                    mids++;
                end
                if (scl_hi_phase) hip++;
                rel++;
            end
            prev_oe = scl_oe;
        end
    end

    // Driver: program counts, queue expectations, run, then disable.
    task automatic run_case(input logic [1:0] spd, input int sh, input int sl,
                            input int fh, input int fl, input int hh, input int hl,
                            input int s, input int eh, input int el, input int n,
                            input int nohs_lo, input string tag);
        exp_t e;
        int   c;
        @(posedge clk); #2;
        spd_sel = spd;
        std_hi = CNT_W'(sh); std_lo = CNT_W'(sl);
        fst_hi = CNT_W'(fh); fst_lo = CNT_W'(fl);
        hsp_hi = CNT_W'(hh); hsp_lo = CNT_W'(hl);
        stretch_n = s;
        for (int i = 0; i < n; i++) begin
            e.lo  = el + 1;
            e.rel = s + eh + 8;
            e.mid = s + 3 + ((eh + 4) >> 1);
            e.hip = eh + 5;
            e.tag = tag;
            exp_q.push_back(e);
            pending++;
        end
        enable = 1'b1;
        @(negedge clk);
        check(!scl_oe, {tag, " R9 not yet started"}, scl_oe, 0);
        @(negedge clk);
        check(scl_oe && lo_start_stb, {tag, " R9 low starts"}, {scl_oe, lo_start_stb}, 3);
        if (nohs_lo >= 0) begin
            c = nh_oe ? 1 : 0;
            while (nh_oe) begin
                @(negedge clk);
                if (nh_oe) c++;
            end
            check(c == nohs_lo, "R5 fallback low length", c, nohs_lo);
        end
        while (pending != 0) @(negedge clk);
        @(posedge clk); #2;
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_idle({tag, " R9 released after disable"});
        repeat (6) @(negedge clk);
        check_idle({tag, " R1 idle while disabled"});
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R1 after reset");
        // Pairs chosen so each speed gives distinct lengths.
        run_case(2'b01, 10, 12, 7, 9, 6, 8, 0, 10, 12, 3, -1, "R2 R3 R4 R8 standard");
        run_case(2'b10, 10, 12, 7, 9, 6, 8, 0, 7, 9, 3, -1, "R3 R4 fast");
        run_case(2'b11, 10, 12, 7, 9, 6, 8, 0, 6, 8, 3, 10, "R4 R5 high");
        run_case(2'b00, 10, 12, 7, 9, 6, 8, 0, 10, 12, 2, -1, "R4 reserved code");
        run_case(2'b01, 2, 3, 7, 9, 6, 8, 0, 6, 8, 2, -1, "R6 clamp standard");
        run_case(2'b10, 10, 12, 5, 7, 6, 8, 0, 6, 8, 2, -1, "R6 clamp fast");
        run_case(2'b10, 10, 12, 7, 9, 6, 8, 5, 7, 9, 3, -1, "R7 R8 stretch5");
        run_case(2'b01, 11, 14, 7, 9, 6, 8, 1, 11, 14, 2, -1, "R7 stretch1");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog R1..all actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule